// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two identical count channels. Each channel has a low and a high count register and a 4-bit configuration nibble. The nibble selects one of four counting modes, chooses between internal ticks and an external count pin, and enables gating by an external level. A run bit per channel starts and stops counting. An overflow flag per channel is set when the active counter rolls over. The flag is cleared by a control-register write or by an acknowledge pulse from the interrupt logic.

In timer use, a channel advances on every `mc_tick` pulse, which marks one machine cycle. In counter use, the channel samples its count pin on each `mc_tick`. It advances once after a sample of 1 is followed by a sample of 0, so a pulse must last at least one machine cycle high and one low to be seen. Gating lets a pin level hold counting off, so the channel measures how long that pin stays high. Software reaches the counts, the configuration and the control bits through a byte-wide write port and a combinational read port.

Top module: `dual_timer_unit`

## Requirements
- R1: Reset clears both channels' count registers, the mode byte, both run bits and both overflow flags, so every address reads 0.
- R2: A channel with its select bit at 0 (timer use) advances its active counter by exactly one on each `mc_tick` pulse while enabled.
- R3: Mode 00: bits [4:0] of the low register count as a divide-by-32 prescaler. The high register advances when they wrap from 31 to 0. Low bits [7:5] keep their value. The flag is set when the high register wraps from FF.
- R4: Mode 01: high:low form one 16-bit up-counter, and the flag is set on the wrap from FFFF to 0000.
- R5: Mode 10: the low register counts. On a step from FF it loads the high register's value and sets the flag. The high register is unchanged.
- R6: When channel 0 is in mode 11, its low register counts as an 8-bit counter under channel 0's enable and flag. Its high register advances on every `mc_tick` while channel 1's run bit is 1, and setting channel 1's flag on its wrap from FF. A rollover of channel 1 sets no flag while channel 0 is split.
- R7: Channel 1 in mode 11 holds both of its count registers.
- R8: With the select bit at 1, a channel advances once for each pair of consecutive `mc_tick` samples of its count pin that read 1 then 0. A pin held at either level gives no count.
- R9: A channel is enabled when its run bit is 1 and either its gate bit is 0 or its `gate_pin` is 1.
- R10: A flag is set on its rollover and cleared by an `ovf_ack` pulse. If a rollover and an acknowledge fall in the same cycle, the flag ends up set. A control write loads the flags from the written bits.
- R11: A bus write to a count register in the same cycle as a count step stores the written value, and that channel does not step in that cycle.
- R12: Address map: 0/1 hold channel 0's low/high registers, and 2/3 hold channel 1's low/high registers. Address 4 is the mode byte. Each channel's nibble is gate[3], select[2], mode[1:0], with channel 0's nibble in bits [3:0] and channel 1's nibble in bits [7:4]. Address 5 is control: run0[0], run1[1], flag0[2], flag1[3]. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_tick | input | 1 | One-cycle pulse per machine cycle |
| cnt_pin | input | 2 | External count pins, one per channel (already synchronized) |
| gate_pin | input | 2 | External gate levels, one per channel (already synchronized) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| ovf_ack | input | 2 | Per-channel flag acknowledge pulse |
| ovf_flag | output | 2 | Per-channel overflow flags |

## Verification
The bench builds the block with its default values: an 8-bit register width and a 5-bit prescaler. At these sizes every wrap is only a few ticks from a preloaded value. This covers the prescaler carry, the 16-bit wrap, the reload from the high register and the split high-counter wrap. Each needs only a handful of `mc_tick` pulses. The narrow prescaler also brings in the case where low bits [7:5] must keep their value while bits [4:0] wrap.

// File: rtl/tc_pkg.sv
// Package: shared types and address constants for the dual timer/counter.
// Assumes two channels and a 3-bit register address space.
package tc_pkg;
    localparam int NUM_CH = 2;
    localparam int CFG_W  = 4;

    typedef enum logic [1:0] {
        MODE_PRESC  = 2'b00,
        MODE_WIDE   = 2'b01,
        MODE_RELOAD = 2'b10,
        MODE_SPLIT  = 2'b11
    } tc_mode_e;

    typedef struct packed {
        logic     gate_en;
        logic     ext_sel;
        tc_mode_e mode;
    } tc_cfg_t;

    localparam logic [2:0] ADR_MODE = 3'd4;
    localparam logic [2:0] ADR_CTRL = 3'd5;
endpackage

// File: rtl/tc_edge_sense.sv
// Module: samples a count pin once per machine cycle and emits a one-cycle
// pulse, one clock after the sample edge, when a 1 sample is followed by a 0.
// Assumes the pin is already synchronized to clk.
module tc_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic pin,
    output logic fall
);
    logic last_q;

    // Hold the previous sample and register the 1-then-0 detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            fall   <= 1'b0;
        end else begin
            fall <= sample_en & last_q & ~pin;
            if (sample_en) begin
                last_q <= pin;
            end
        end
    end
endmodule

// File: rtl/tc_channel.sv
// Module: one count channel with low/high registers and four modes.
// SPLIT_HOST marks the channel that becomes two counters in mode 11; any
// other channel halts in mode 11. Bus writes override the step for one cycle.
module tc_channel
    import tc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PRE_W      = 5,
    parameter bit SPLIT_HOST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              fall,
    input  logic              gate_lvl,
    input  logic              run,
    input  logic              hi_run,
    input  tc_cfg_t           cfg,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] lo,
    output logic [DATA_W-1:0] hi,
    output logic              ovf_main,
    output logic              ovf_aux
);
    localparam logic [DATA_W-1:0]   ONE_D   = DATA_W'(1);
    localparam logic [2*DATA_W-1:0] ONE_W   = (2*DATA_W)'(1);
    localparam logic [PRE_W-1:0]    ONE_P   = PRE_W'(1);
    localparam logic [DATA_W-1:0]   TOP_D   = '1;
    localparam logic [2*DATA_W-1:0] TOP_W   = '1;
    localparam logic [PRE_W-1:0]    TOP_P   = '1;

    logic              enable;
    logic              step;
    logic [DATA_W-1:0] lo_n;
    logic [DATA_W-1:0] hi_n;
    logic              raw_main;
    logic              raw_aux;

    assign enable = run & (~cfg.gate_en | gate_lvl);
    assign step   = enable & (cfg.ext_sel ? fall : mc_tick);

    // Next-state and rollover detection for the selected mode.
    always_comb begin
        lo_n     = lo;
        hi_n     = hi;
        raw_main = 1'b0;
        raw_aux  = 1'b0;
        case (cfg.mode)
            MODE_PRESC: begin
                if (step) begin
                    if (lo[PRE_W-1:0] == TOP_P) begin
                        lo_n[PRE_W-1:0] = '0;
                        hi_n            = hi + ONE_D;
                        raw_main        = (hi == TOP_D);
                    end else begin
                        lo_n[PRE_W-1:0] = lo[PRE_W-1:0] + ONE_P;
                    end
                end
            end
            MODE_WIDE: begin
                if (step) begin
                    {hi_n, lo_n} = {hi, lo} + ONE_W;
                    raw_main     = ({hi, lo} == TOP_W);
                end
            end
            MODE_RELOAD: begin
                if (step) begin
                    if (lo == TOP_D) begin
                        lo_n     = hi;
                        raw_main = 1'b1;
                    end else begin
                        lo_n = lo + ONE_D;
                    end
                end
            end
            MODE_SPLIT: begin
                if (SPLIT_HOST) begin
                    if (step) begin
                        lo_n     = lo + ONE_D;
                        raw_main = (lo == TOP_D);
                    end
                    if (mc_tick && hi_run) begin
                        hi_n    = hi + ONE_D;
                        raw_aux = (hi == TOP_D);
                    end
                end
            end
        endcase
        if (wr_lo || wr_hi) begin
            lo_n     = wr_lo ? wr_data : lo;
            hi_n     = wr_hi ? wr_data : hi;
            raw_main = 1'b0;
            raw_aux  = 1'b0;
        end
    end

    assign ovf_main = raw_main;
    assign ovf_aux  = raw_aux;

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= lo_n;
            hi <= hi_n;
        end
    end
endmodule

// File: rtl/dual_timer_unit.sv
// Module: two timer/counter channels with mode byte, control byte, flags
// and a byte register port. Assumes DATA_W >= 8 and synchronized pins.
module dual_timer_unit
    import tc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        ovf_ack,
    output logic [1:0]        ovf_flag
);
    localparam int MODE_W = NUM_CH * CFG_W;

    logic [MODE_W-1:0]                mode_q;
    logic [NUM_CH-1:0]                run_q;
    logic [NUM_CH-1:0]                flag_q;
    logic [NUM_CH-1:0][DATA_W-1:0]    ch_lo;
    logic [NUM_CH-1:0][DATA_W-1:0]    ch_hi;
    logic [NUM_CH-1:0]                fall;
    logic [NUM_CH-1:0]                ovf_main;
    logic [NUM_CH-1:0]                ovf_aux;
    logic [NUM_CH-1:0]                flag_set;
    tc_cfg_t                          cfg [NUM_CH];
    logic                             split_on;
    logic                             ctrl_wr;

    assign ctrl_wr  = wr_en && (wr_addr == ADR_CTRL);
    assign split_on = (cfg[0].mode == MODE_SPLIT);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign cfg[g] = tc_cfg_t'(mode_q[g*CFG_W +: CFG_W]);

        tc_edge_sense u_edge (
            .clk       (clk),
            .rst_n     (rst_n),
            .sample_en (mc_tick),
            .pin       (cnt_pin[g]),
            .fall      (fall[g])
        );

        tc_channel #(
            .DATA_W     (DATA_W),
            .PRE_W      (PRE_W),
            .SPLIT_HOST (g == 0)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .mc_tick  (mc_tick),
            .fall     (fall[g]),
            .gate_lvl (gate_pin[g]),
            .run      (run_q[g]),
            .hi_run   (run_q[NUM_CH-1]),
            .cfg      (cfg[g]),
            .wr_lo    (wr_en && (wr_addr == 3'(2*g))),
            .wr_hi    (wr_en && (wr_addr == 3'(2*g+1))),
            .wr_data  (wr_data),
            .lo       (ch_lo[g]),
            .hi       (ch_hi[g]),
            .ovf_main (ovf_main[g]),
            .ovf_aux  (ovf_aux[g])
        );
    end

    assign flag_set[0] = ovf_main[0];
    assign flag_set[1] = split_on ? ovf_aux[0] : (ovf_main[1] | ovf_aux[1]);

    // Mode byte and run bits written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
        end else begin
            if (wr_en && (wr_addr == ADR_MODE)) begin
                mode_q <= wr_data[MODE_W-1:0];
            end
            if (ctrl_wr) begin
                run_q <= wr_data[NUM_CH-1:0];
            end
        end
    end

    // Overflow flags: bus write, then rollover, then acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ctrl_wr) begin
                    flag_q[i] <= wr_data[NUM_CH+i];
                end else if (flag_set[i]) begin
                    flag_q[i] <= 1'b1;
                end else if (ovf_ack[i]) begin
                    flag_q[i] <= 1'b0;
                end
            end
        end
    end

    assign ovf_flag = flag_q;

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            3'd0:     rd_data = ch_lo[0];
            3'd1:     rd_data = ch_hi[0];
            3'd2:     rd_data = ch_lo[1];
            3'd3:     rd_data = ch_hi[1];
            ADR_MODE: rd_data = DATA_W'(mode_q);
            ADR_CTRL: rd_data = DATA_W'({flag_q, run_q});
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tc_checker.sv
// Module: property checks for dual_timer_unit, bound to every instance.
module tc_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        gate_pin,
    input logic [1:0]        ovf_ack,
    input logic [1:0]        ovf_flag,
    input logic [1:0]        run,
    input logic [7:0]        mode_byte,
    input logic [DATA_W-1:0] lo0,
    input logic [DATA_W-1:0] lo1,
    input logic [DATA_W-1:0] hi1
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (ovf_flag == 2'b00) && (run == 2'b00)); // R1

    AST_CH1_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_byte[5:4] == 2'b11) && !(wr_en && (wr_addr == 3'd2 || wr_addr == 3'd3))
        |=> $stable(lo1) && $stable(hi1)); // R7

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run[0] && !(wr_en && wr_addr == 3'd0) |=> $stable(lo0)); // R9

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run[0] && mode_byte[3] && !gate_pin[0] && !(wr_en && wr_addr == 3'd0)
        |=> $stable(lo0)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag[0] && !ovf_ack[0] && !(wr_en && wr_addr == 3'd5)
        |=> ovf_flag[0]); // R10

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == 3'd0) |=> lo0 == $past(wr_data)); // R11
endmodule

bind dual_timer_unit tc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .gate_pin  (gate_pin),
    .ovf_ack   (ovf_ack),
    .ovf_flag  (ovf_flag),
    .run       (run_q),
    .mode_byte (mode_q),
    .lo0       (ch_lo[0]),
    .lo1       (ch_lo[1]),
    .hi1       (ch_hi[1])
);

// File: tb/sim_dual_timer_unit.sv
`timescale 1ns/1ps
module sim_dual_timer_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic [1:0] cnt_pin = 2'b00;
    logic [1:0] gate_pin = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic [1:0] ovf_ack = 2'b00;
    logic [1:0] ovf_flag;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dual_timer_unit u0 (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ovf_ack(ovf_ack), .ovf_flag(ovf_flag)
    );

    // Fields: mode, ctrl, lo, hi, gate, ticks, exp lo, exp hi, exp flags
    localparam logic [71:0] VECS [10] = '{
        72'h01_01_FE_00_01_03_01_01_00,
        72'h01_01_FF_FF_01_01_00_00_01,
        72'h00_01_1E_05_01_02_00_06_00,
        72'h00_01_FF_00_01_01_E0_01_00,
        72'h00_01_1F_FF_01_01_00_00_01,
        72'h02_01_FE_80_01_03_81_80_01,
        72'h02_01_FF_FF_01_02_FF_FF_01,
        72'h01_00_10_20_01_05_10_20_00,
        72'h09_01_10_20_00_05_10_20_00,
        72'h09_01_10_20_01_05_15_20_00
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic tick();
        @(negedge clk);
        mc_tick = 1'b1;
        @(negedge clk);
        mc_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [71:0] v);
        if (v[57:56] != 2'b01 || v[67] == 1'b1) return "R9 gate/run";
        case (v[65:64])
            2'b00:   return "R3 prescaled";
            2'b01:   return "R4 16-bit R2";
            default: return "R5 reload";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R12 unused address reads 0
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reset/R12 map", d, 8'h00);
        end

        // Vector table
        for (int i = 0; i < 10; i++) begin
            logic [71:0] v;
            v = VECS[i];
            wr(3'd5, 8'h00);
            wr(3'd4, v[71:64]);
            wr(3'd0, v[55:48]);
            wr(3'd1, v[47:40]);
            gate_pin = v[33:32];
            wr(3'd5, v[63:56]);
            for (int t = 0; t < int'(v[31:24]); t++) tick();
            rd(3'd0, d); check(tag_of(v), d, v[23:16]);
            rd(3'd1, d); check(tag_of(v), d, v[15:8]);
            rd(3'd5, d); check({tag_of(v), " R10 flag"}, {6'b0, d[3:2]}, v[7:0]);
        end
        gate_pin = 2'b00;

        // R10 ack clears, set beats ack, control write clears
        wr(3'd5, 8'h00); wr(3'd4, 8'h01); wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        wr(3'd5, 8'h01);
        tick();
        check("R10 flag pin set", {6'b0, ovf_flag}, 8'h01);
        @(negedge clk); ovf_ack = 2'b01;
        @(negedge clk); ovf_ack = 2'b00;
        rd(3'd5, d); check("R10 ack clears", d, 8'h01);
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        @(negedge clk); mc_tick = 1'b1; ovf_ack = 2'b01;
        @(negedge clk); mc_tick = 1'b0; ovf_ack = 2'b00;
        rd(3'd5, d); check("R10 set beats ack", d, 8'h05);
        wr(3'd5, 8'h01);
        rd(3'd5, d); check("R10 ctrl write clears", d, 8'h01);

        // R11 write in the same cycle as a step
        wr(3'd0, 8'h10); wr(3'd1, 8'h00);
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h55; mc_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; mc_tick = 1'b0;
        rd(3'd0, d); check("R11 write wins lo", d, 8'h55);
        rd(3'd1, d); check("R11 no step hi", d, 8'h00);

        // R8 external edge counting
        wr(3'd5, 8'h00); wr(3'd4, 8'h04); wr(3'd0, 8'h00); wr(3'd5, 8'h01);
        cnt_pin = 2'b01; tick();
        cnt_pin = 2'b00; tick();
        rd(3'd0, d); check("R8 one falling edge", d, 8'h01);
        tick(); tick();
        rd(3'd0, d); check("R8 held low no count", d, 8'h01);
        cnt_pin = 2'b01; tick(); tick();
        rd(3'd0, d); check("R8 rising/held high no count", d, 8'h01);
        cnt_pin = 2'b00; tick();
        rd(3'd0, d); check("R8 second falling edge", d, 8'h02);

        // R6 split mode on channel 0, channel 1 in 16-bit mode
        wr(3'd5, 8'h00); wr(3'd4, 8'h13);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd5, 8'h01);
        tick();
        rd(3'd0, d); check("R6 split lo counts", d, 8'h01);
        rd(3'd1, d); check("R6 split hi needs run1", d, 8'h00);
        wr(3'd5, 8'h03);
        tick(); tick();
        rd(3'd0, d); check("R6 split lo", d, 8'h03);
        rd(3'd1, d); check("R6 split hi", d, 8'h02);
        rd(3'd2, d); check("R6 ch1 still counts", d, 8'h01);
        rd(3'd5, d); check("R6 ch1 rollover no flag", d, 8'h03);
        wr(3'd1, 8'hFE);
        tick(); tick();
        rd(3'd1, d); check("R6 split hi wraps", d, 8'h00);
        rd(3'd5, d); check("R6 split hi sets flag1", d, 8'h0B);

        // R7 channel 1 halts in mode 11
        wr(3'd5, 8'h00); wr(3'd4, 8'h30); wr(3'd2, 8'h05); wr(3'd3, 8'h07);
        wr(3'd5, 8'h02);
        tick(); tick(); tick();
        rd(3'd2, d); check("R7 ch1 lo halted", d, 8'h05);
        rd(3'd3, d); check("R7 ch1 hi halted", d, 8'h07);
        rd(3'd4, d); check("R12 mode byte readback", d, 8'h30);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule